// File: doc/BRIEF.md
# Bus-Idle Sleep Timer

This block decides when a small serial-bus slave may stop its internal oscillator. It watches the clock and data lines of the two-wire bus together with a busy flag raised by the rest of the chip. The bus is idle when both lines are high and busy is low. Each idle cycle is counted, and the count restarts from zero whenever the bus is not idle. When the idle run reaches a programmable number of timeout steps, the block enters sleep and raises `sleepEn`, which gates the oscillator off through `oscEn`.

One step is `PRESCALE_CYCLES` clock cycles. The default is 32768 cycles of an 8 MHz clock, about 4.096 ms. The step count lives in a 13-bit register. It resets to its maximum of 8057 steps, about 33 s. After an initialisation window that follows reset, the host may load a new value through a single-cycle write strobe.

Wake-up does not rely on the clock, because the clock is stopped during sleep. A low level on either bus line removes `sleepEn` combinationally. On the next clock edge the block enters a restart phase that lasts `RESTART_CYCLES` cycles, which covers the oscillator's settling time. After that phase, idle counting starts again from zero.

Top module: `idle_sleep_ctrl`

## Requirements
- R1: Sleep is entered on the clock edge that completes `timeout × PRESCALE_CYCLES` consecutive idle cycles. A cycle is idle when `sclIn=1`, `sdaIn=1` and `busy=0`.
- R2: During and after reset, `sleepEn=0` and `oscEn=1`, and the timeout register holds `MAX_STEPS`.
- R3: A host write of 0 stores 1. A write above `MAX_STEPS` stores `MAX_STEPS`. Any other value is stored unchanged.
- R4: A write presented on any of the first `INIT_CYCLES` clock edges after reset release is ignored.
- R5: While asleep, a low level on `sclIn` or `sdaIn` drops `sleepEn` in the same cycle, with no clock edge needed. `oscEn` is always the inverse of `sleepEn`.
- R6: After a wake, `RESTART_CYCLES` edges pass before idle cycles are counted again. While asleep, `busy` does not cause a wake.
- R7: Any non-idle cycle discards the idle run, so the full timeout must elapse again from zero.
- R8: If the timeout is lowered during an idle run, sleep is entered at the next step boundary where the number of elapsed steps is at least the new value. A write on the same edge as a boundary does not affect that boundary's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| busy | input | 1 | High while any internal function is active |
| cfgWrEn | input | 1 | Single-cycle timeout write strobe |
| cfgWrData | input | STEP_W | Timeout in steps |
| sleepEn | output | 1 | High while asleep |
| oscEn | output | 1 | Oscillator enable, the inverse of sleepEn |

## Verification
Two functions can land on one edge: the step boundary that completes the timeout, and an event that would stop it.

The first such event is a bus line falling in the very last idle cycle. The bench provokes this after a settled wake by holding the bus idle for exactly one cycle less than the timeout, then dropping a line. The expected result is that no sleep occurs.

The second is a host write landing on the completing edge. The bench provokes this with the same idle run, but places the write on the final idle cycle. The expected result is that sleep is entered, because the old timeout governs that edge.

A behavioural model counts idle cycles in plain integers. It judges both cases, as well as a long randomised run, on every cycle and again between edges.

// File: rtl/idle_sleep_pkg.sv
package idle_sleep_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE  = 2'd0,
    MODE_SLEEP   = 2'd1,
    MODE_RESTART = 2'd2
  } sleepMode_e;

  // Strobes from the mode controller to the counting datapath
  typedef struct packed {
    logic clrCount;    // zero prescaler and step counter
    logic runCount;    // advance prescaler by one idle cycle
    logic runRestart;  // advance the oscillator settling counter
  } sleepCtl_t;

endpackage

// File: rtl/idle_sleep_dp.sv
module idle_sleep_dp
  import idle_sleep_pkg::*;
#(
  parameter int PRESCALE_CYCLES = 32768,
  parameter int STEP_W          = 13,
  parameter int MAX_STEPS       = 8057,
  parameter int INIT_CYCLES     = 112000,
  parameter int RESTART_CYCLES  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sleepCtl_t         ctl,
  input  logic              cfgWrEn,
  input  logic [STEP_W-1:0] cfgWrData,
  output logic              stepHit,
  output logic              restartDone
);

  localparam int PRE_W  = (PRESCALE_CYCLES > 1) ? $clog2(PRESCALE_CYCLES) : 1;
  localparam int RST_W  = (RESTART_CYCLES > 1) ? $clog2(RESTART_CYCLES) : 1;
  localparam int INIT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(PRESCALE_CYCLES - 1);
  localparam logic [RST_W-1:0]  RST_LAST  = RST_W'(RESTART_CYCLES - 1);
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYCLES);
  localparam logic [STEP_W-1:0] MAX_V     = STEP_W'(MAX_STEPS);

  logic [PRE_W-1:0]  preCnt;
  logic [STEP_W-1:0] stepCnt;
  logic [STEP_W-1:0] timeoutReg;
  logic [STEP_W-1:0] wrVal;
  logic [RST_W-1:0]  restartCnt;
  logic [INIT_W-1:0] initCnt;
  logic              initDone;

  assign initDone = (initCnt == INIT_LAST);

  // Host value clamped into the legal step range
  always_comb begin
    if (cfgWrData == '0)       wrVal = STEP_W'(1);
    else if (cfgWrData > MAX_V) wrVal = MAX_V;
    else                        wrVal = cfgWrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      initCnt    <= '0;
      timeoutReg <= MAX_V;
    end else begin
      if (!initDone) initCnt <= initCnt + INIT_W'(1);
      if (initDone && cfgWrEn) timeoutReg <= wrVal;
    end
  end

  // Prescaler and step counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt  <= '0;
      stepCnt <= '0;
    end else if (ctl.clrCount) begin
      preCnt  <= '0;
      stepCnt <= '0;
    end else if (ctl.runCount) begin
      if (preCnt == PRE_LAST) begin
        preCnt  <= '0;
        stepCnt <= stepCnt + STEP_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  assign stepHit = (preCnt == PRE_LAST) &&
                   (({1'b0, stepCnt} + (STEP_W+1)'(1)) >= {1'b0, timeoutReg});

  // Oscillator settling counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                restartCnt <= '0;
    else if (!ctl.runRestart)  restartCnt <= '0;
    else if (!restartDone)     restartCnt <= restartCnt + RST_W'(1);
  end

  assign restartDone = (restartCnt == RST_LAST);

  p_timeout_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (timeoutReg != '0) && (timeoutReg <= MAX_V));

  p_locked_in_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !initDone |-> (timeoutReg == MAX_V));

  p_clear_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clrCount |=> ((preCnt == '0) && (stepCnt == '0)));

endmodule

// File: rtl/idle_sleep_fsm.sv
module idle_sleep_fsm
  import idle_sleep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      busy,
  input  logic      stepHit,
  input  logic      restartDone,
  output sleepCtl_t ctl,
  output logic      sleepEn
);

  sleepMode_e mode, modeNext;
  logic linesHigh, busIdle;

  assign linesHigh = sclIn & sdaIn;
  assign busIdle   = linesHigh & ~busy;

  always_comb begin
    modeNext = mode;
    ctl      = '0;
    case (mode)
      MODE_ACTIVE: begin
        if (busIdle && stepHit) begin
          modeNext     = MODE_SLEEP;
          ctl.clrCount = 1'b1;
        end else if (busIdle) begin
          ctl.runCount = 1'b1;
        end else begin
          ctl.clrCount = 1'b1;
        end
      end
      MODE_SLEEP: begin
        ctl.clrCount = 1'b1;
        if (!linesHigh) modeNext = MODE_RESTART;
      end
      MODE_RESTART: begin
        ctl.clrCount   = 1'b1;
        ctl.runRestart = 1'b1;
        if (restartDone) modeNext = MODE_ACTIVE;
      end
      default: modeNext = MODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_ACTIVE;
    else        mode <= modeNext;
  end

  // Wake path: line levels gate the registered sleep state directly
  assign sleepEn = (mode == MODE_SLEEP) & linesHigh;

  p_sleep_on_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == MODE_SLEEP) |-> $past(sclIn && sdaIn && !busy));

  p_wake_to_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_SLEEP) && !(sclIn && sdaIn)) |=> (mode == MODE_RESTART));

  p_no_skip_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SLEEP) |=> (mode != MODE_ACTIVE));

endmodule

// File: rtl/idle_sleep_ctrl.sv
module idle_sleep_ctrl
  import idle_sleep_pkg::*;
#(
  parameter int PRESCALE_CYCLES = 32768,
  parameter int STEP_W          = 13,
  parameter int MAX_STEPS       = 8057,
  parameter int INIT_CYCLES     = 112000,
  parameter int RESTART_CYCLES  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              busy,
  input  logic              cfgWrEn,
  input  logic [STEP_W-1:0] cfgWrData,
  output logic              sleepEn,
  output logic              oscEn
);

  sleepCtl_t ctl;
  logic stepHit, restartDone;

  idle_sleep_fsm uFsm (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn), .busy(busy),
    .stepHit(stepHit), .restartDone(restartDone), .ctl(ctl), .sleepEn(sleepEn)
  );

  idle_sleep_dp #(
    .PRESCALE_CYCLES(PRESCALE_CYCLES), .STEP_W(STEP_W), .MAX_STEPS(MAX_STEPS),
    .INIT_CYCLES(INIT_CYCLES), .RESTART_CYCLES(RESTART_CYCLES)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .stepHit(stepHit), .restartDone(restartDone)
  );

  assign oscEn = ~sleepEn;

  p_osc_on_when_line_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclIn || !sdaIn) |-> oscEn);

endmodule

// File: tb/idle_sleep_ctrl_test.sv
module idle_sleep_ctrl_test;

  localparam int PRE = 8;
  localparam int SW  = 13;
  localparam int MAXS = 6;
  localparam int INIT = 20;
  localparam int RST  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclIn = 1'b1, sdaIn = 1'b1, busy = 1'b0, cfgWrEn = 1'b0;
  logic [SW-1:0] cfgWrData = '0;
  logic sleepEn, oscEn;

  int nChecks = 0, nFail = 0, cycleCnt = 0;
  string curReq = "R2";

  // reference model state
  int mMode = 0, mIdle = 0, mRst = 0, mTmo = MAXS, mEdges = 0;

  always #2.5 clk = ~clk;

  idle_sleep_ctrl #(
    .PRESCALE_CYCLES(PRE), .STEP_W(SW), .MAX_STEPS(MAXS),
    .INIT_CYCLES(INIT), .RESTART_CYCLES(RST)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn), .busy(busy),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .sleepEn(sleepEn), .oscEn(oscEn)
  );

  function automatic int clampStep(int v);
    if (v == 0) return 1;
    if (v > MAXS) return MAXS;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mMode = 0; mIdle = 0; mRst = 0; mTmo = MAXS; mEdges = 0;
    end else begin
      int oldTmo;
      oldTmo = mTmo;
      if (mEdges >= INIT && cfgWrEn) mTmo = clampStep(int'(cfgWrData));
      if (mEdges < INIT) mEdges++;
      case (mMode)
        0: if (sclIn && sdaIn && !busy) begin
             mIdle++;
             if ((mIdle % PRE) == 0 && (mIdle / PRE) >= oldTmo) begin
               mMode = 1; mIdle = 0;
             end
           end else mIdle = 0;
        1: if (!(sclIn && sdaIn)) begin mMode = 2; mRst = 0; end
        default: begin
          mRst++;
          if (mRst == RST) begin mMode = 0; mIdle = 0; end
        end
      endcase
    end
  end

  task automatic chk();
    logic exp;
    exp = (mMode == 1) && sclIn && sdaIn;
    nChecks++;
    if (sleepEn !== exp || oscEn !== !exp) begin
      nFail++;
      $display("FAIL %s: sleepEn=%0b oscEn=%0b expected sleepEn=%0b oscEn=%0b",
               curReq, sleepEn, oscEn, exp, !exp);
    end
  endtask

  // one cycle: check, drive, check again between edges
  task automatic cyc(input logic s, input logic d, input logic b,
                     input logic w, input int data);
    @(negedge clk);
    chk();
    sclIn = s; sdaIn = d; busy = b; cfgWrEn = w; cfgWrData = SW'(data);
    #1;
    chk();
  endtask

  task automatic idleFor(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 0, 0);
  endtask

  task automatic wakeSettle();
    for (int i = 0; i < RST + 3; i++) cyc(0, 0, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 150000) begin
      nFail++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycleCnt);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    // R2: reset state
    curReq = "R2";
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    // R4: early write ignored (would give 1-step timeout)
    curReq = "R4";
    cyc(1, 1, 0, 1, 1);
    idleFor(10);
    // R2: default maximum timeout reached from reset release
    curReq = "R2";
    idleFor(50);
    // R5: combinational wake on data line
    curReq = "R5";
    cyc(1, 0, 0, 0, 0);
    // R6: restart phase with lines high
    curReq = "R6";
    idleFor(RST + 10);
    // R3: zero clamps to one step
    curReq = "R3";
    cyc(1, 1, 0, 1, 0);
    idleFor(12);
    cyc(0, 1, 0, 0, 0);
    wakeSettle();
    cyc(1, 1, 0, 1, 9);
    idleFor(55);
    // R6: busy while asleep does not wake
    curReq = "R6";
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0, 0);
    curReq = "R5";
    cyc(0, 1, 0, 0, 0);
    wakeSettle();
    // R7: interruptions restart the run
    curReq = "R7";
    cyc(1, 1, 0, 1, 3);
    idleFor(20);
    cyc(1, 1, 1, 0, 0);
    idleFor(20);
    cyc(0, 1, 0, 0, 0);
    idleFor(30);
    cyc(1, 0, 0, 0, 0);
    wakeSettle();
    // R8: lowering the timeout mid-run
    curReq = "R8";
    cyc(0, 0, 0, 1, 5);
    idleFor(20);
    cyc(1, 1, 0, 1, 1);
    idleFor(10);
    cyc(0, 0, 0, 0, 0);
    wakeSettle();
    // R1: line drop in last idle cycle, then write on completing edge
    curReq = "R1";
    cyc(0, 0, 0, 1, 4);
    idleFor(31);
    cyc(1, 0, 0, 0, 0);
    idleFor(31);
    cyc(1, 1, 0, 1, 6);
    idleFor(3);
    wakeSettle();
    // R1: randomised traffic
    for (int i = 0; i < 3000; i++) begin
      logic s, d, b, w;
      s = ($urandom_range(0, 19) != 0);
      d = ($urandom_range(0, 19) != 0);
      b = ($urandom_range(0, 29) == 0);
      w = ($urandom_range(0, 39) == 0);
      cyc(s, d, b, w, int'($urandom_range(0, 9)));
    end
    @(negedge clk);
    chk();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule